// File: doc/BRIEF.md
# Audio Clock Ratio Checker

This block supervises the three clocks of an audio serial port: the system (master) clock, the bit clock and the word (frame) clock. It runs entirely on a free-running reference clock. Each incoming clock passes through a two-flop synchronizer, and its rising edges are detected in the reference domain. Between two rising edges of the word clock, the block counts reference cycles, system-clock rising edges and bit-clock rising edges.

At the end of each frame, the reference-cycle count places the sample rate into one of three bands, or marks it as out of range. The system-clock and bit-clock counts are then tested against the ratios that are legal for that band. A frame with an error must repeat in the next frame before the error flag rises. The flag falls only after two good frames in a row. While the flag shows a ratio fault, a mute output tells the serial data path to drive zeros. For sources whose system clock is not an audio multiple, the system-clock ratio test can be switched off.

Top module: `audio_clock_ratio_checker`

## Requirements
- R1: A frame whose period lies outside the 8 kHz to 192 kHz range with 5 % slack reports cause code 1 (rate error). The range ends at about 7.6 kHz and about 201.6 kHz. A word clock that shows no rising edge for REF_HZ/7600 reference cycles also ends a frame with cause code 1. A rate error does not raise the mute output.
- R2: In the low band (rates up to about 68 kHz), a system-clock count per frame of 128, 256, 384, 512 or 768 is legal. Any other count reports cause code 2 (system-clock error).
- R3: In the middle band (about 68 kHz to 136 kHz), the legal system-clock counts are 128, 256, 384 and 512. A count of 768 or any other value reports cause code 2.
- R4: In the high band (about 136 kHz to 201.6 kHz), only system-clock counts of 128 and 256 are legal. Any other count, 512 included, reports cause code 2.
- R5: In every band, a bit-clock count per frame of 32, 48, 64 or 256 is legal. Any other count reports cause code 3 (bit-clock error).
- R6: The mute output is high exactly while the error flag is set with cause code 2 or 3.
- R7: When sys_chk_en is low, a system-clock count that would be illegal produces no cause code 2.
- R8: When one frame has several faults, the cause is chosen by priority: rate error (1) first, then system-clock error (2), then bit-clock error (3).
- R9: The error flag is set only after two consecutive bad frames. A single bad frame leaves the error flag and the cause code 0 unchanged.
- R10: Once set, the error flag and the cause code are held until two consecutive good frames have been seen. After that, both return to 0.
- R11: While reset is asserted, and after it is released until the first frame verdict, the error flag, the cause code and the mute output are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sys_clk_in | input | 1 | Audio system clock, asynchronous |
| bit_clk_in | input | 1 | Audio bit clock, asynchronous |
| word_clk_in | input | 1 | Audio word clock, asynchronous; its rising edge delimits frames |
| sys_chk_en | input | 1 | High enables the system-clock ratio test |
| clk_err | output | 1 | Filtered clock error flag |
| err_cause | output | 2 | 0 none, 1 rate, 2 system-clock ratio, 3 bit-clock ratio |
| mute_out | output | 1 | Force serial data output to zero |

## Verification
The design makes a decision once per word-clock period. A fault inside it therefore shows at the ports within about three word-clock periods of applying a clock set. Three faults show up this way:
- An off-by-one counter, or a band split in the wrong place, shows as a legal ratio being flagged, or an illegal one passing, on the third rising edge of the word clock.
- A wrong filter state shows as the flag rising after the second edge instead of the third, or as the flag being released after one good frame instead of two.
- A broken stall timeout shows as the rate error missing after two timeout windows of a stopped word clock.

// File: rtl/acr_pkg.sv
package acr_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_RATE = 2'd1,
    CAUSE_SYS  = 2'd2,
    CAUSE_BIT  = 2'd3
  } cause_e;

  typedef enum logic [1:0] {
    BAND_LOW  = 2'd0,
    BAND_MID  = 2'd1,
    BAND_HIGH = 2'd2,
    BAND_OUT  = 2'd3
  } band_e;
endpackage

// File: rtl/acr_edge_sync.sv
module acr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q;

  always_comb sync_d = {sync_q[STAGES-2:0], async_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/acr_frame_meter.sv
module acr_frame_meter #(
  parameter int PER_W     = 15,
  parameter int RAT_W     = 10,
  parameter int PER_LIMIT = 26315
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck_rise,
  input  logic             bck_rise,
  input  logic             wck_rise,
  output logic             done_o,
  output logic             tmo_o,
  output logic [PER_W-1:0] period_o,
  output logic [RAT_W-1:0] sck_n_o,
  output logic [RAT_W-1:0] bck_n_o
);
  logic [PER_W-1:0] per_q, per_d, period_q, period_d;
  logic [RAT_W-1:0] sck_q, sck_d, bck_q, bck_d, sckn_q, sckn_d, bckn_q, bckn_d;
  logic [RAT_W-1:0] sck_sum, bck_sum;
  logic             primed_q, primed_d, done_q, done_d, tmo_q, tmo_d;
  logic             per_full, cap_en;

  always_comb begin
    sck_sum  = (sck_q == '1) ? sck_q : sck_q + RAT_W'(sck_rise);
    bck_sum  = (bck_q == '1) ? bck_q : bck_q + RAT_W'(bck_rise);
    per_full = (per_q == PER_W'(PER_LIMIT));
    per_d    = per_q + 1'b1;
    sck_d    = sck_sum;
    bck_d    = bck_sum;
    primed_d = primed_q;
    done_d   = 1'b0;
    tmo_d    = 1'b0;
    cap_en   = 1'b0;
    period_d = per_q + 1'b1;
    sckn_d   = sck_sum;
    bckn_d   = bck_sum;
    if (wck_rise) begin
      per_d    = '0;
      sck_d    = '0;
      bck_d    = '0;
      primed_d = 1'b1;
      done_d   = primed_q;
      cap_en   = primed_q;
    end else if (per_full) begin
      per_d    = '0;
      sck_d    = '0;
      bck_d    = '0;
      primed_d = 1'b0;
      done_d   = 1'b1;
      tmo_d    = 1'b1;
      cap_en   = 1'b1;
      period_d = per_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q    <= '0;
      sck_q    <= '0;
      bck_q    <= '0;
      primed_q <= 1'b0;
      done_q   <= 1'b0;
      tmo_q    <= 1'b0;
      period_q <= '0;
      sckn_q   <= '0;
      bckn_q   <= '0;
    end else begin
      per_q    <= per_d;
      sck_q    <= sck_d;
      bck_q    <= bck_d;
      primed_q <= primed_d;
      done_q   <= done_d;
      tmo_q    <= tmo_d;
      if (cap_en) begin
        period_q <= period_d;
        sckn_q   <= sckn_d;
        bckn_q   <= bckn_d;
      end
    end
  end

  assign done_o   = done_q;
  assign tmo_o    = tmo_q;
  assign period_o = period_q;
  assign sck_n_o  = sckn_q;
  assign bck_n_o  = bckn_q;
endmodule

// File: rtl/acr_ratio_judge.sv
module acr_ratio_judge
  import acr_pkg::*;
#(
  parameter int PER_W    = 15,
  parameter int RAT_W    = 10,
  parameter int SLOW_LIM = 26315,
  parameter int FAST_LIM = 992,
  parameter int TH_LO    = 2941,
  parameter int TH_HI    = 1470
) (
  input  logic             tmo,
  input  logic [PER_W-1:0] period,
  input  logic [RAT_W-1:0] sck_n,
  input  logic [RAT_W-1:0] bck_n,
  input  logic             sys_chk_en,
  output cause_e           cause_o
);
  band_e band;
  logic  sck_ok, bck_ok;

  always_comb begin
    if (tmo || period > PER_W'(SLOW_LIM) || period < PER_W'(FAST_LIM)) band = BAND_OUT;
    else if (period >= PER_W'(TH_LO)) band = BAND_LOW;
    else if (period >= PER_W'(TH_HI)) band = BAND_MID;
    else band = BAND_HIGH;
  end

  always_comb begin
    case (sck_n)
      RAT_W'(128), RAT_W'(256): sck_ok = 1'b1;
      RAT_W'(384), RAT_W'(512): sck_ok = (band != BAND_HIGH);
      RAT_W'(768):              sck_ok = (band == BAND_LOW);
      default:                  sck_ok = 1'b0;
    endcase
    case (bck_n)
      RAT_W'(32), RAT_W'(48), RAT_W'(64), RAT_W'(256): bck_ok = 1'b1;
      default:                                         bck_ok = 1'b0;
    endcase
  end

  always_comb begin
    if (band == BAND_OUT)           cause_o = CAUSE_RATE;
    else if (sys_chk_en && !sck_ok) cause_o = CAUSE_SYS;
    else if (!bck_ok)               cause_o = CAUSE_BIT;
    else                            cause_o = CAUSE_NONE;
  end
endmodule

// File: rtl/acr_err_filter.sv
module acr_err_filter
  import acr_pkg::*;
#(
  parameter int CONFIRM = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_done,
  input  cause_e     cause_in,
  output logic       err_o,
  output logic [1:0] cause_o,
  output logic       mute_o
);
  localparam int CNT_W = $clog2(CONFIRM + 1);

  logic [CNT_W-1:0] bad_q, bad_d, good_q, good_d;
  logic             flag_q, flag_d;
  cause_e           cause_q, cause_d;

  always_comb begin
    bad_d   = bad_q;
    good_d  = good_q;
    flag_d  = flag_q;
    cause_d = cause_q;
    if (frame_done) begin
      if (cause_in != CAUSE_NONE) begin
        good_d = '0;
        bad_d  = (bad_q == CNT_W'(CONFIRM)) ? bad_q : bad_q + 1'b1;
        if (bad_q >= CNT_W'(CONFIRM - 1)) begin
          flag_d  = 1'b1;
          cause_d = cause_in;
        end
      end else begin
        bad_d  = '0;
        good_d = (good_q == CNT_W'(CONFIRM)) ? good_q : good_q + 1'b1;
        if (good_q >= CNT_W'(CONFIRM - 1)) begin
          flag_d  = 1'b0;
          cause_d = CAUSE_NONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bad_q   <= '0;
      good_q  <= '0;
      flag_q  <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else if (frame_done) begin
      bad_q   <= bad_d;
      good_q  <= good_d;
      flag_q  <= flag_d;
      cause_q <= cause_d;
    end
  end

  assign err_o   = flag_q;
  assign cause_o = cause_q;
  assign mute_o  = flag_q && (cause_q == CAUSE_SYS || cause_q == CAUSE_BIT);
endmodule

// File: rtl/audio_clock_ratio_checker.sv
module audio_clock_ratio_checker
  import acr_pkg::*;
#(
  parameter int REF_HZ      = 200_000_000,
  parameter int MIN_FS_HZ   = 8000,
  parameter int MAX_FS_HZ   = 192000,
  parameter int TOL_PCT     = 5,
  parameter int SPLIT_LO_HZ = 68000,
  parameter int SPLIT_HI_HZ = 136000,
  parameter int SYNC_STAGES = 2,
  parameter int RAT_W       = 10,
  parameter int CONFIRM     = 2
) (
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic       sys_clk_in,
  input  logic       bit_clk_in,
  input  logic       word_clk_in,
  input  logic       sys_chk_en,
  output logic       clk_err,
  output logic [1:0] err_cause,
  output logic       mute_out
);
  localparam int NUM_CLKS = 3;
  localparam int SLOW_LIM = REF_HZ / (MIN_FS_HZ - MIN_FS_HZ * TOL_PCT / 100);
  localparam int FAST_LIM = REF_HZ / (MAX_FS_HZ + MAX_FS_HZ * TOL_PCT / 100);
  localparam int TH_LO    = REF_HZ / SPLIT_LO_HZ;
  localparam int TH_HI    = REF_HZ / SPLIT_HI_HZ;
  localparam int PER_W    = $clog2(SLOW_LIM + 2);

  logic                rst_meta_q, rst_sync_q;
  logic [NUM_CLKS-1:0] raw_clks, clk_rise;
  logic                meter_done, meter_tmo;
  logic [PER_W-1:0]    meter_period;
  logic [RAT_W-1:0]    meter_sck, meter_bck;
  cause_e              judged_cause;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign raw_clks = {word_clk_in, bit_clk_in, sys_clk_in};

  generate
    for (genvar g = 0; g < NUM_CLKS; g++) begin : g_sync
      acr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk_ref),
        .rst_n    (rst_sync_q),
        .async_in (raw_clks[g]),
        .rise_o   (clk_rise[g])
      );
    end
  endgenerate

  acr_frame_meter #(.PER_W(PER_W), .RAT_W(RAT_W), .PER_LIMIT(SLOW_LIM)) u_meter (
    .clk      (clk_ref),
    .rst_n    (rst_sync_q),
    .sck_rise (clk_rise[0]),
    .bck_rise (clk_rise[1]),
    .wck_rise (clk_rise[2]),
    .done_o   (meter_done),
    .tmo_o    (meter_tmo),
    .period_o (meter_period),
    .sck_n_o  (meter_sck),
    .bck_n_o  (meter_bck)
  );

  acr_ratio_judge #(
    .PER_W(PER_W), .RAT_W(RAT_W), .SLOW_LIM(SLOW_LIM),
    .FAST_LIM(FAST_LIM), .TH_LO(TH_LO), .TH_HI(TH_HI)
  ) u_judge (
    .tmo        (meter_tmo),
    .period     (meter_period),
    .sck_n      (meter_sck),
    .bck_n      (meter_bck),
    .sys_chk_en (sys_chk_en),
    .cause_o    (judged_cause)
  );

  acr_err_filter #(.CONFIRM(CONFIRM)) u_filter (
    .clk        (clk_ref),
    .rst_n      (rst_sync_q),
    .frame_done (meter_done),
    .cause_in   (judged_cause),
    .err_o      (clk_err),
    .cause_o    (err_cause),
    .mute_o     (mute_out)
  );
endmodule

// File: rtl/acr_checker.sv
module acr_checker (
  input logic       clk_ref,
  input logic       rst_n,
  input logic       sys_chk_en,
  input logic       clk_err,
  input logic [1:0] err_cause,
  input logic       mute_out,
  input logic       frame_done,
  input logic       frame_tmo,
  input logic [1:0] judged_cause
);
  // R9: the flag only rises on a frame verdict that was bad
  a_r9_rise_needs_bad_frame: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(clk_err) |-> $past(frame_done && judged_cause != 2'd0));

  // R10: the flag only falls on a frame verdict that was good
  a_r10_fall_needs_good_frame: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $fell(clk_err) |-> $past(frame_done && judged_cause == 2'd0));

  // R10: outputs hold between frame verdicts
  a_r10_hold_between_frames: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !$past(frame_done) |-> ($stable(err_cause) && $stable(clk_err) && $stable(mute_out)));

  // R1: a stalled word clock yields a rate verdict
  a_r1_stall_is_rate: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (frame_done && frame_tmo) |-> judged_cause == 2'd1);

  // R7: with the system-clock test off, no system-clock verdict appears
  a_r7_disabled_no_sys: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (frame_done && !sys_chk_en) |-> judged_cause != 2'd2);

  // R11: outputs are quiet right after reset release
  a_r11_quiet_after_reset: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(rst_n) |-> (!clk_err && !mute_out && err_cause == 2'd0));
endmodule

bind audio_clock_ratio_checker acr_checker u_acr_checker (
  .clk_ref      (clk_ref),
  .rst_n        (rst_n),
  .sys_chk_en   (sys_chk_en),
  .clk_err      (clk_err),
  .err_cause    (err_cause),
  .mute_out     (mute_out),
  .frame_done   (meter_done),
  .frame_tmo    (meter_tmo),
  .judged_cause (judged_cause)
);

// File: tb/tb_audio_clock_ratio_checker.sv
`timescale 1ns/1ps
module tb_audio_clock_ratio_checker;
  // one vector: sck half period in 5 ns ticks, sck periods per bck period,
  // bck periods per frame, enable, expected cause
  typedef struct packed {
    int         sh;
    int         dv;
    int         br;
    logic       en;
    logic [1:0] cause;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2, 12,  64, 1'b1, 2'd0},  // R2 low band, 768/64
    '{3, 16,  32, 1'b1, 2'd0},  // R2 low band, 512/32
    '{5,  5,  64, 1'b1, 2'd2},  // R2 low band, 320 illegal
    '{4,  8,  48, 1'b1, 2'd0},  // R5 low band, 384/48
    '{6,  1, 256, 1'b1, 2'd0},  // R5 bck 256
    '{6,  2, 128, 1'b1, 2'd3},  // R5 bck 128 illegal
    '{5,  8,  40, 1'b1, 2'd2},  // R8 both ratios bad
    '{5,  5,  64, 1'b0, 2'd0},  // R7 check disabled
    '{2,  8,  64, 1'b1, 2'd0},  // R3 mid band, 512
    '{1, 12,  64, 1'b1, 2'd2},  // R3 mid band, 768 illegal
    '{2,  4,  64, 1'b1, 2'd0},  // R4 high band, 256
    '{1,  8,  64, 1'b1, 2'd2},  // R4 high band, 512 illegal
    '{1,  4,  32, 1'b1, 2'd1},  // R1 rate too high
    '{1,  3,  40, 1'b1, 2'd1}   // R8 rate beats ratio faults
  };

  function automatic string tag_of(int i);
    case (i)
      0, 1, 2: return "R2";
      3, 4, 5: return "R5";
      6, 13:   return "R8";
      7:       return "R7";
      8, 9:    return "R3";
      10, 11:  return "R4";
      default: return "R1";
    endcase
  endfunction

  logic       clk, rst_n, sys_chk_en;
  logic       clk_err, mute_out;
  logic [1:0] err_cause;
  logic       sck, bck, wck;
  logic       run;
  int         n, sh, dv, br;
  int         checks, fails;

  audio_clock_ratio_checker dut (
    .clk_ref     (clk),
    .rst_n       (rst_n),
    .sys_clk_in  (sck),
    .bit_clk_in  (bck),
    .word_clk_in (wck),
    .sys_chk_en  (sys_chk_en),
    .clk_err     (clk_err),
    .err_cause   (err_cause),
    .mute_out    (mute_out)
  );

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  // audio time base: edges at 1.25 ns + k*5 ns, away from reference edges
  initial begin
    n = 0; sh = 1; dv = 1; br = 1; run = 1'b0;
    #1.25;
    forever begin
      #5;
      if (run) n = n + 1;
    end
  end

  assign sck = ((n / sh) % 2) == 1;
  assign bck = ((n / (sh * dv)) % 2) == 1;
  assign wck = ((n / (sh * dv * br)) % 2) == 1;

  task automatic check(string tag, logic [1:0] exp_cause);
    logic exp_err, exp_mute;
    exp_err  = (exp_cause != 2'd0);
    exp_mute = (exp_cause == 2'd2) || (exp_cause == 2'd3);
    checks++;
    if (clk_err !== exp_err || err_cause !== exp_cause || mute_out !== exp_mute) begin
      fails++;
      $display("FAIL %s: err/cause/mute got %b/%0d/%b expected %b/%0d/%b",
               tag, clk_err, err_cause, mute_out, exp_err, exp_cause, exp_mute);
    end
  endtask

  task automatic restart(int s, int d, int b, logic en);
    @(negedge clk);
    run = 1'b0; n = 0; rst_n = 1'b0;
    sh = s; dv = d; br = b; sys_chk_en = en;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run = 1'b1;
  endtask

  task automatic wait_rises(int k);
    repeat (k) @(posedge wck);
    repeat (10) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    checks = 0; fails = 0;
    rst_n = 1'b0; sys_chk_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 in reset", 2'd0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R11 after release", 2'd0);

    for (int i = 0; i < NV; i++) begin
      restart(VECS[i].sh, VECS[i].dv, VECS[i].br, VECS[i].en);
      wait_rises(3);
      check($sformatf("%s vec %0d", tag_of(i), i), VECS[i].cause);
    end

    // R9 / R10: confirm and release filtering, R6 mute tracking
    restart(5, 5, 64, 1'b1);
    wait_rises(2);
    check("R9 one bad frame", 2'd0);
    wait_rises(1);
    check("R6 flagged with mute", 2'd2);
    sys_chk_en = 1'b0;
    wait_rises(1);
    check("R10 one good frame holds", 2'd2);
    wait_rises(1);
    check("R10 two good frames clear", 2'd0);

    // R1: stopped word clock, stall timeout
    restart(1, 1, 1, 1'b1);
    run = 1'b0;
    repeat (26400) @(negedge clk);
    check("R9 one stall window", 2'd0);
    repeat (26650) @(negedge clk);
    check("R1 stalled word clock", 2'd1);

    summary();
    $finish;
  end
endmodule